// File: doc/BRIEF.md
# Receive FIFO with Fill-Level Interrupt

This block buffers words arriving from a serial receiver until software collects them. The receiver side offers one word per cycle on a push strobe. The processor side takes the oldest word with a pop strobe. The block reports the number of stored words as a 5-bit occupancy value, from 0 (empty) to 16 (full).

A programmable 5-bit threshold is compared with the occupancy. Whenever the occupancy is greater than or equal to the threshold, a sticky flag is set. The flag stays set until software writes a configuration word with its clear bit at one. The interrupt output is the flag gated by an enable bit. The threshold resets to 31, which lies above the storage depth, so no interrupt can arise until software programs a reachable threshold.

Occupancy is tracked by a three-state fill machine:

- **FS_EMPTY** accepts pushes and ignores pops.
- **FS_PARTIAL** accepts both pushes and pops.
- **FS_FULL** accepts pops and drops pushes, pulsing an overflow indication for each dropped push.

The machine has five transitions:

- *fill_start*: FS_EMPTY to FS_PARTIAL on an accepted push.
- *fill_top*: FS_PARTIAL to FS_FULL when the 16th word is stored.
- *drain_top*: FS_FULL to FS_PARTIAL on an accepted pop.
- *drain_last*: FS_PARTIAL to FS_EMPTY when the last word leaves.
- *hold*: the state is kept in every other case.

Top module: `rxq_level_fifo`

## Requirements
- R1: After reset:
  - `fill_count` is 0;
  - `level_q` is 31;
  - `irq_en_q`, `flag`, `irq` and `overflow` are 0;
  - `pop_data` is 0.
- R2: `fill_count` rises by one for each accepted push and falls by one for each accepted pop. It updates at the clock edge that samples the strobe and always stays within 0 to 16.
- R3: Words leave in the order they arrived. The word for a pop sampled at an edge appears on `pop_data` after that edge.
- R4: When `fill_count >= level_q` at a clock edge, `flag` is 1 after the following edge.
- R5: The flag is sticky. Once set, it stays 1 after the occupancy drops below the threshold, until it is cleared.
- R6: Clearing the flag:
  - A configuration write (`cfg_wr`=1) with `cfg_clr`=1 clears the flag.
  - A write with `cfg_clr`=0 leaves the flag unchanged.
  - When the set condition of R4 holds in the same cycle as a clear, the flag stays 1.
- R7: `irq` equals `flag` AND `irq_en_q`. A configuration write loads `level_q` from `cfg_level` and `irq_en_q` from `cfg_irq_en`.
- R8: A push while 16 words are stored is dropped. `fill_count` stays 16, and `overflow` is 1 for the one cycle after that edge. The dropped word never appears on `pop_data`.
- R9: A pop while empty leaves `fill_count` at 0 and `pop_data` unchanged.
- R10: With `level_q` above 16, the flag never sets, whatever the occupancy.
- R11: A push and a pop in the same cycle with between 1 and 15 words stored leave `fill_count` unchanged, and the pop still returns the oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | Receiver offers a word this cycle |
| push_data | input | 8 | Word from the receiver |
| pop_req | input | 1 | Processor takes the oldest word |
| pop_data | output | 8 | Last word popped (registered) |
| fill_count | output | 5 | Number of stored words, 0 to 16 |
| overflow | output | 1 | One-cycle pulse after a dropped push |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_level | input | 5 | Threshold value written on cfg_wr |
| cfg_irq_en | input | 1 | Interrupt enable written on cfg_wr |
| cfg_clr | input | 1 | Write-one-to-clear for the flag, sampled on cfg_wr |
| level_q | output | 5 | Current threshold |
| irq_en_q | output | 1 | Current interrupt enable |
| flag | output | 1 | Sticky level-reached flag |
| irq | output | 1 | Interrupt output |

## Verification
The assertions assume synchronous strobes that are free of X after reset. They also assume that the configuration fields carry meaningful values only while `cfg_wr` is high. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It presents `cfg_level`, `cfg_irq_en` and `cfg_clr` together with `cfg_wr`, so every sampled strobe is a complete, deliberate request. The threshold sweep covers 0 to 17 and 31, pushing from empty to full and draining back. It also adds directed cases for overflow, an empty pop, simultaneous push and pop, and a clear that collides with a set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY,
        FS_PARTIAL,
        FS_FULL
    } fill_state_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // pointers wrap at the last slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    // registered read port: holds the last word when no pop is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_ptr];
    end

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/rxq_occupancy.sv
module rxq_occupancy
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W-1:0] count,
    output logic             overflow
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    fill_state_t      state_q;
    fill_state_t      state_d;
    logic [CNT_W-1:0] count_d;
    logic             drop;

    // output / acceptance process
    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        drop    = 1'b0;
        unique case (state_q)
            FS_EMPTY: begin
                push_ok = push_req;
            end
            FS_PARTIAL: begin
                push_ok = push_req;
                pop_ok  = pop_req;
            end
            FS_FULL: begin
                pop_ok = pop_req;
                drop   = push_req;
            end
            default: ;
        endcase
    end

    always_comb begin
        count_d = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        if (count_d == '0)           state_d = FS_EMPTY;
        else if (count_d == CNT_FULL) state_d = FS_FULL;
        else                          state_d = FS_PARTIAL;
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FS_EMPTY;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            state_q  <= state_d;
            count    <= count_d;
            overflow <= drop;
        end
    end

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_FULL);

    assert_state_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == FS_EMPTY) == (count == '0)) &&
        ((state_q == FS_FULL) == (count == CNT_FULL)));

    assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_FULL && push_req && !pop_req) |=> (count == CNT_FULL) && overflow);

    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop_req && !push_req) |=> (count == '0));

    assert_push_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && count != CNT_FULL && push_req && pop_req) |=> $stable(count));

endmodule

// File: rtl/rxq_level_irq.sv
module rxq_level_irq #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_level,
    input  logic             cfg_en,
    input  logic             cfg_clr,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] level_q,
    output logic             en_q,
    output logic             flag,
    output logic             irq
);
    logic hit;
    logic clr_hit;

    assign hit     = (count >= level_q);
    assign clr_hit = cfg_wr && cfg_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '1;
            en_q    <= 1'b0;
            flag    <= 1'b0;
        end else begin
            if (cfg_wr) begin
                level_q <= cfg_level;
                en_q    <= cfg_en;
            end
            // set has priority over the write-one clear
            if (hit)          flag <= 1'b1;
            else if (clr_hit) flag <= 1'b0;
        end
    end

    assign irq = flag && en_q;

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= level_q) |=> flag);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(cfg_wr && cfg_clr)) |=> flag);

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_clr && count < level_q) |=> !flag);

    assert_high_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && level_q > CNT_W'(DEPTH)) |=> !flag);

endmodule

// File: rtl/rxq_level_fifo.sv
module rxq_level_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] pop_data,
    output logic [CNT_W-1:0] fill_count,
    output logic             overflow,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_level,
    input  logic             cfg_irq_en,
    input  logic             cfg_clr,
    output logic [CNT_W-1:0] level_q,
    output logic             irq_en_q,
    output logic             flag,
    output logic             irq
);
    logic push_ok;
    logic pop_ok;

    rxq_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_valid),
        .pop_req  (pop_req),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .count    (fill_count),
        .overflow (overflow)
    );

    rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_ok),
        .wr_data (push_data),
        .rd_en   (pop_ok),
        .rd_data (pop_data)
    );

    rxq_level_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_level (cfg_level),
        .cfg_en    (cfg_irq_en),
        .cfg_clr   (cfg_clr),
        .count     (fill_count),
        .level_q   (level_q),
        .en_q      (irq_en_q),
        .flag      (flag),
        .irq       (irq)
    );

    assert_irq_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_irq_en) |=> !irq);

endmodule

// File: tb/sim_rxq_level_fifo.sv
module sim_rxq_level_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic [4:0] fill_count;
    logic       overflow;
    logic       cfg_wr = 1'b0;
    logic [4:0] cfg_level = '0;
    logic       cfg_irq_en = 1'b0;
    logic       cfg_clr = 1'b0;
    logic [4:0] level_q;
    logic       irq_en_q;
    logic       flag;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rxq_level_fifo u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
        .pop_req(pop_req), .pop_data(pop_data), .fill_count(fill_count),
        .overflow(overflow), .cfg_wr(cfg_wr), .cfg_level(cfg_level),
        .cfg_irq_en(cfg_irq_en), .cfg_clr(cfg_clr), .level_q(level_q),
        .irq_en_q(irq_en_q), .flag(flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        push_valid = 1'b0; pop_req = 1'b0; cfg_wr = 1'b0; cfg_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d);
        push_valid = 1'b1; push_data = d;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    task automatic pop();
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
    endtask

    task automatic push_pop(input logic [7:0] d);
        push_valid = 1'b1; push_data = d; pop_req = 1'b1;
        @(negedge clk);
        push_valid = 1'b0; pop_req = 1'b0;
    endtask

    task automatic cfg(input int lvl, input bit en, input bit clr);
        cfg_wr = 1'b1; cfg_level = 5'(lvl); cfg_irq_en = en; cfg_clr = clr;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_clr = 1'b0;
    endtask

    function automatic logic [7:0] word(input int l, input int i);
        return 8'(l * 7 + i * 13 + 1);
    endfunction

    task automatic run_level(input int l);
        bit seen;
        do_reset();
        cfg(l, 1'b1, 1'b0);
        idle();
        seen = (l == 0);
        check("R4 flag at empty", int'(flag), int'(seen));
        for (int i = 0; i < 16; i++) begin
            push(word(l, i));
            check("R2 count on push", int'(fill_count), i + 1);
            idle();
            if (i + 1 >= l) seen = 1'b1;
            if (l > 16) check("R10 high level", int'(flag), 0);
            else        check("R4 flag vs level", int'(flag), int'(seen));
            check("R7 irq enabled", int'(irq), int'(seen));
        end
        for (int i = 0; i < 16; i++) begin
            pop();
            check("R3 order", int'(pop_data), int'(word(l, i)));
            check("R2 count on pop", int'(fill_count), 15 - i);
            check("R5 sticky", int'(flag), int'(seen));
        end
        cfg(l, 1'b1, 1'b0);
        idle();
        check("R6 write zero", int'(flag), int'(seen));
        cfg(l, 1'b1, 1'b1);
        idle();
        check("R6 clear", int'(flag), int'(l == 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 count", int'(fill_count), 0);
        check("R1 level", int'(level_q), 31);
        check("R1 enable", int'(irq_en_q), 0);
        check("R1 flag", int'(flag), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 overflow", int'(overflow), 0);
        check("R1 pop_data", int'(pop_data), 0);

        // level sweep, including unreachable levels (R10)
        for (int l = 0; l <= 17; l++) run_level(l);
        run_level(31);

        // R7 enable gating
        do_reset();
        cfg(2, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) push(8'(i));
        idle();
        check("R7 flag set while disabled", int'(flag), 1);
        check("R7 irq masked", int'(irq), 0);
        cfg(2, 1'b1, 1'b0);
        check("R7 irq unmasked", int'(irq), 1);

        // R8 overflow
        do_reset();
        for (int i = 0; i < 16; i++) push(8'(100 + i));
        check("R8 full count", int'(fill_count), 16);
        check("R8 no overflow before", int'(overflow), 0);
        push(8'hEE);
        check("R8 overflow pulse", int'(overflow), 1);
        check("R8 count held", int'(fill_count), 16);
        idle();
        check("R8 pulse ends", int'(overflow), 0);
        for (int i = 0; i < 16; i++) begin
            pop();
            check("R8 dropped word absent", int'(pop_data), 100 + i);
        end

        // R9 pop while empty
        pop();
        check("R9 data held", int'(pop_data), 115);
        check("R9 count stays", int'(fill_count), 0);

        // R11 simultaneous push and pop
        push(8'h21);
        push(8'h22);
        push_pop(8'h23);
        check("R11 count unchanged", int'(fill_count), 2);
        check("R11 oldest out", int'(pop_data), 'h21);
        pop();
        check("R11 second", int'(pop_data), 'h22);
        pop();
        check("R11 third", int'(pop_data), 'h23);
        check("R11 drained", int'(fill_count), 0);

        // R6 set wins over clear
        do_reset();
        cfg(1, 1'b1, 1'b0);
        push(8'h5A);
        idle();
        check("R6 flag set", int'(flag), 1);
        cfg(1, 1'b1, 1'b1);
        check("R6 set wins", int'(flag), 1);
        pop();
        cfg(1, 1'b1, 1'b1);
        check("R6 clear after drain", int'(flag), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule